// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card bus clock from a fast host clock. Two stages run in cascade. A power-of-two prescaler produces a tick every few host cycles. A linear divisor counts those ticks and toggles the card clock. The total ratio between the host clock and the card clock is the prescale ratio times the divisor.

Software controls the block through one 32-bit control word. The word holds the two divider fields, a card-clock enable, a peripheral-clock enable, a data-timeout selector and a self-clearing reset-all bit. The card clock runs only while both enables are set. The divider settings that are actually in use are captured only while the clock is stopped, so a divider change can never produce a runt pulse.

Besides the card clock, the block gives a one-cycle strobe on each rising edge of the card clock, a flag that shows the clock has completed its first full period, and the clamped timeout selector for the data path.

Top module: `sdclk_gen`

## Requirements
- R1: After the synchronous active-low reset, the read-back word is 0, and the card clock, its rise strobe and its stable flag are all 0.
- R2: The card clock period is 2·F·(D+1) host cycles. D is bits 7:4 of the control word, so the divisor runs from 1 to 16. F is the prescale field in bits 15:8, which holds half the prescale ratio (1, 2, 4 … 128 for ratios 2 to 256).
- R3: The card clock is high for exactly half of its period and low for the other half.
- R4: The card clock is held low unless both bit 3 (card-clock enable) and bit 2 (peripheral-clock enable) are 1. After a write sets both bits, the first rising edge comes F·(D+1) host cycles after the write edge.
- R5: The rise strobe is high for one host cycle, and that cycle is the first cycle in which the card clock is high.
- R6: The stable flag rises in the cycle in which the card clock first falls after it was enabled. The flag returns to 0 whenever the clock is gated.
- R7: A write that changes bits 15:4 while the clock is running changes the read-back value but not the running period. The new fields take effect at the next enable that follows a disable.
- R8: If the prescale field has more than one bit set, only its highest set bit counts. A field of zero acts as F=1.
- R9: The 4-bit timeout field in bits 19:16 is stored, read back and driven on the timeout output. A written value of 15 is clamped to 14.
- R10: Writing 1 to bit 24 clears every field and gates the clock. Bit 24 then reads 1 for RST_CYCLES host cycles and clears itself. Writes made while bit 24 reads 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 32 | Control word written on a strobe |
| ctl_rdata | output | 32 | Current control word, with bit 24 showing that reset-all is busy |
| data_tmo | output | 4 | Clamped data-timeout selector |
| sd_clk | output | 1 | Card clock |
| sd_clk_rise | output | 1 | One-cycle strobe on each card clock rising edge |
| sd_clk_stable | output | 1 | Card clock has completed its first full period |

## Verification
The divider is exercised with the smallest total ratio (2) and the largest (4096), and with mixed settings of 6 and 40. These settings tell apart the factor taken from the prescaler and the factor taken from the linear stage, as well as off-by-one errors in each. Prescale fields with several bits set, or with no bit set, separate a highest-bit decode from other decodes. Rewriting the divider while the clock runs, and then cycling the enable, shows whether the active settings are latched only while the clock is stopped. The reset-all scenario measures the busy window and checks that a write during that window leaves no trace.

// File: rtl/sdclk_pkg.sv
// Package: shared widths, control-word bit positions and field type for the
// SD card clock divider. Bit positions are fixed because software decodes them.
package sdclk_pkg;
    localparam int CTL_W      = 32;
    localparam int PRE_W      = 8;
    localparam int DIV_W      = 4;
    localparam int TMO_W      = 4;
    localparam int POS_PEREN  = 2;
    localparam int POS_CKEN   = 3;
    localparam int POS_DIV    = 4;
    localparam int POS_PRE    = 8;
    localparam int POS_TMO    = 16;
    localparam int POS_RSTALL = 24;
    localparam logic [TMO_W-1:0] TMO_MAX = 4'd14;

    typedef struct packed {
        logic [TMO_W-1:0] tmo;
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] div;
        logic             cken;
        logic             peren;
    } ctl_fields_t;
endpackage

// File: rtl/sdclk_ctl.sv
// Module: control-word register with reset-all sequencer.
// Holds the programmed fields, clamps the timeout selector and captures the
// active divider settings only while the card clock is stopped.
// Assumes: one write per strobe; writes are ignored while reset-all is busy.
module sdclk_ctl
    import sdclk_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] rd_data,
    output ctl_fields_t      fields,
    output logic [PRE_W-1:0] act_pre,
    output logic [DIV_W-1:0] act_div,
    output logic             busy
);
    localparam int RCNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [RCNT_W-1:0] RCNT_LOAD = RCNT_W'(RST_CYCLES - 1);

    logic [RCNT_W-1:0] rst_cnt;
    logic [TMO_W-1:0]  tmo_in;
    logic              running;

    // Clamp the incoming timeout selector to its legal maximum.
    always_comb begin
        tmo_in = wr_data[POS_TMO +: TMO_W];
        if (tmo_in > TMO_MAX) tmo_in = TMO_MAX;
    end

    assign running = fields.cken & fields.peren;

    // Register updates, reset-all countdown and active-divider capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields  <= '0;
            act_pre <= '0;
            act_div <= '0;
            busy    <= 1'b0;
            rst_cnt <= '0;
        end else if (busy) begin
            if (rst_cnt == '0) busy <= 1'b0;
            else               rst_cnt <= rst_cnt - 1'b1;
        end else if (wr_en) begin
            if (wr_data[POS_RSTALL]) begin
                fields  <= '0;
                act_pre <= '0;
                act_div <= '0;
                busy    <= 1'b1;
                rst_cnt <= RCNT_LOAD;
            end else begin
                fields.tmo   <= tmo_in;
                fields.pre   <= wr_data[POS_PRE +: PRE_W];
                fields.div   <= wr_data[POS_DIV +: DIV_W];
                fields.cken  <= wr_data[POS_CKEN];
                fields.peren <= wr_data[POS_PEREN];
                if (!running) begin
                    act_pre <= wr_data[POS_PRE +: PRE_W];
                    act_div <= wr_data[POS_DIV +: DIV_W];
                end
            end
        end
    end

    // Assemble the read-back word.
    always_comb begin
        rd_data                     = '0;
        rd_data[POS_TMO +: TMO_W]   = fields.tmo;
        rd_data[POS_PRE +: PRE_W]   = fields.pre;
        rd_data[POS_DIV +: DIV_W]   = fields.div;
        rd_data[POS_CKEN]           = fields.cken;
        rd_data[POS_PEREN]          = fields.peren;
        rd_data[POS_RSTALL]         = busy;
    end
endmodule

// File: rtl/sdclk_prescale.sv
// Module: power-of-two prescaler stage.
// Emits one tick every F host cycles, where F is the highest set bit of the
// prescale field (zero field acts as F=1). Held cleared while run is low.
module sdclk_prescale
    import sdclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_field,
    output logic             tick
);
    logic [PRE_W-1:0] pval;
    logic [PRE_W-1:0] cnt;

    // Decode the field to its highest set bit; zero defaults to one.
    always_comb begin
        pval = PRE_W'(1);
        for (int i = 0; i < PRE_W; i++) begin
            if (pre_field[i]) pval = PRE_W'(1) << i;
        end
    end

    assign tick = run && (cnt == pval - 1'b1);

    // Host-cycle counter that wraps on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sdclk_lindiv.sv
// Module: linear divisor stage and output flops.
// Counts D+1 prescaler ticks per half period, toggles the card clock and
// produces the rise strobe and the stable flag. Held low while run is low.
module sdclk_lindiv
    import sdclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_m1,
    output logic             sd_clk,
    output logic             sd_rise,
    output logic             stable
);
    logic [DIV_W-1:0] cnt;

    // Tick counter, clock toggle, rise strobe and first-period flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt     <= '0;
            sd_clk  <= 1'b0;
            sd_rise <= 1'b0;
            stable  <= 1'b0;
        end else begin
            sd_rise <= 1'b0;
            if (tick) begin
                if (cnt == div_m1) begin
                    cnt     <= '0;
                    sd_clk  <= ~sd_clk;
                    sd_rise <= ~sd_clk;
                    if (sd_clk) stable <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sdclk_gen.sv
// Module: top of the SD card clock divider.
// Connects the control register, the prescaler and the linear divisor.
// Assumes: software stops the clock before relying on new divider fields.
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic [31:0] ctl_wdata,
    output logic [31:0] ctl_rdata,
    output logic [3:0]  data_tmo,
    output logic        sd_clk,
    output logic        sd_clk_rise,
    output logic        sd_clk_stable
);
    ctl_fields_t      fields;
    logic [PRE_W-1:0] act_pre;
    logic [DIV_W-1:0] act_div;
    logic             busy;
    logic             run;
    logic             tick;

    sdclk_ctl #(.RST_CYCLES(RST_CYCLES)) i_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr),
        .wr_data (ctl_wdata),
        .rd_data (ctl_rdata),
        .fields  (fields),
        .act_pre (act_pre),
        .act_div (act_div),
        .busy    (busy)
    );

    // Clock runs only with both enables set and no reset-all in progress.
    assign run      = fields.cken & fields.peren & ~busy;
    assign data_tmo = fields.tmo;

    sdclk_prescale i_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .pre_field (act_pre),
        .tick      (tick)
    );

    sdclk_lindiv i_lin (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .div_m1  (act_div),
        .sd_clk  (sd_clk),
        .sd_rise (sd_clk_rise),
        .stable  (sd_clk_stable)
    );
endmodule

// File: rtl/sdclk_gen_chk.sv
// Module: property checker for sdclk_gen, attached with bind.
module sdclk_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ctl_rdata,
    input logic [3:0]  data_tmo,
    input logic        sd_clk,
    input logic        sd_clk_rise,
    input logic        sd_clk_stable
);
    // R4: clock gated one cycle after either enable reads low
    assert_gated_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_rdata[3] && ctl_rdata[2]) |=> !sd_clk);
    // R5: strobe only in the first high cycle
    assert_rise_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sd_clk_rise |-> (sd_clk && !$past(sd_clk)));
    assert_rise_seen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_clk) |-> sd_clk_rise);
    // R6: stable flag appears together with the first falling edge
    assert_stable_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_clk_stable) |-> $fell(sd_clk));
    // R9: timeout selector never exceeds 14
    assert_tmo_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_tmo != 4'd15);
    // R10: reset-all busy stops the card clock
    assert_busy_gates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[24] |=> !sd_clk);
endmodule

bind sdclk_gen sdclk_gen_chk i_sdclk_gen_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_rdata     (ctl_rdata),
    .data_tmo      (data_tmo),
    .sd_clk        (sd_clk),
    .sd_clk_rise   (sd_clk_rise),
    .sd_clk_stable (sd_clk_stable)
);

// File: tb/test_sdclk_gen.sv
module test_sdclk_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic [3:0]  data_tmo;
    logic        sd_clk, sd_clk_rise, sd_clk_stable;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sdclk_gen i_sdclk_gen (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .data_tmo(data_tmo), .sd_clk(sd_clk),
        .sd_clk_rise(sd_clk_rise), .sd_clk_stable(sd_clk_stable)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(int pre, int dm1, bit en);
        return (32'(pre) << 8) | (32'(dm1) << 4) | (en ? 32'hC : 32'h0);
    endfunction

    // Write one word; returns at the falling edge after the capture edge.
    task automatic wr(input logic [31:0] d);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
    endtask

    // Measure period and high cycles between two rise strobes.
    task automatic measure(output int per, output int hi);
        int guard = 0;
        per = 0; hi = 1;
        while (!sd_clk_rise && guard < 10000) begin @(negedge clk); guard++; end
        do begin
            @(negedge clk); per++;
            if (sd_clk) hi++;
        end while (!sd_clk_rise && per < 10000);
        hi--; // last sample belongs to the next period
    endtask

    task automatic t_reset;
        chk(ctl_rdata == 0, "R1 rdata", int'(ctl_rdata), 0);
        chk(!sd_clk && !sd_clk_rise && !sd_clk_stable, "R1 outputs",
            int'({sd_clk, sd_clk_rise, sd_clk_stable}), 0);
    endtask

    // Enable a setting, check first-edge latency, period, duty and stable.
    task automatic t_ratio(input int pre, input int dm1, input int f, input string tag);
        int k = 0, per, hi, n;
        n = 2 * f * (dm1 + 1);
        wr(word(0, 0, 0));
        wr(word(pre, dm1, 1));
        chk(!sd_clk_stable, {tag, " R6 stable low at enable"}, sd_clk_stable, 0);
        while (!sd_clk && k < 10000) begin @(negedge clk); k++; end
        chk(k == f * (dm1 + 1), {tag, " R4 first-rise latency"}, k, f * (dm1 + 1));
        chk(sd_clk_rise, {tag, " R5 strobe at rise"}, sd_clk_rise, 1);
        @(negedge clk);
        chk(!sd_clk_rise || n == 2, {tag, " R5 strobe single"}, sd_clk_rise, 0);
        measure(per, hi);
        chk(per == n, {tag, " R2 period"}, per, n);
        chk(hi == n / 2, {tag, " R3 high time"}, hi, n / 2);
        chk(sd_clk_stable, {tag, " R6 stable after period"}, sd_clk_stable, 1);
    endtask

    task automatic t_gate;
        wr(word(1, 0, 1));
        wr(32'h0000_0108); // card enable only
        repeat (6) begin
            @(negedge clk);
            chk(!sd_clk && !sd_clk_stable, "R4 R6 gated without peripheral enable",
                int'({sd_clk, sd_clk_stable}), 0);
        end
    endtask

    task automatic t_live_change;
        int per, hi;
        wr(word(0, 0, 0));
        wr(word(1, 2, 1));
        wr(word(1, 0, 1));
        chk(ctl_rdata[7:4] == 0, "R7 readback updated", int'(ctl_rdata[7:4]), 0);
        measure(per, hi);
        chk(per == 6, "R7 period unchanged while running", per, 6);
        wr(word(1, 0, 0));
        wr(word(1, 0, 1));
        measure(per, hi);
        chk(per == 2, "R7 new period after re-enable", per, 2);
    endtask

    task automatic t_tmo;
        wr(32'h000F_0000);
        chk(data_tmo == 14 && ctl_rdata[19:16] == 14, "R9 clamp 15", int'(data_tmo), 14);
        wr(32'h0009_0000);
        chk(data_tmo == 9, "R9 value 9", int'(data_tmo), 9);
    endtask

    task automatic t_rstall;
        int b = 0;
        wr(word(4, 3, 1) | 32'h0005_0000);
        repeat (20) @(negedge clk);
        wr(32'h0100_0000);
        chk(ctl_rdata[24], "R10 busy set", ctl_rdata[24], 1);
        while (ctl_rdata[24] && b < 100) begin b++; @(negedge clk); end
        chk(b == 8, "R10 busy length", b, 8);
        chk(ctl_rdata == 0 && !sd_clk, "R10 fields cleared", int'(ctl_rdata), 0);
        wr(32'h0100_0000);
        wr(word(1, 0, 1));
        repeat (12) @(negedge clk);
        chk(ctl_rdata == 0 && !sd_clk, "R10 write while busy ignored", int'(ctl_rdata), 0);
    endtask

    initial begin
        #4_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ratio(8'h01, 0, 1, "min");
        t_ratio(8'h01, 2, 1, "f1d3");
        t_ratio(8'h04, 4, 4, "f4d5");
        t_ratio(8'h80, 15, 128, "max");
        t_ratio(8'h06, 0, 4, "R8 multi-bit");
        t_ratio(8'h00, 1, 1, "R8 zero field");
        t_gate();
        t_live_change();
        t_tmo();
        t_rstall();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule